// File: doc/BRIEF.md
# Prioritized CPU Interrupt Acceptance Unit

This unit sits beside a processor core. It decides when an external interrupt request is taken. Seven request lines are watched continuously. At each instruction boundary the unit picks the most urgent pending line and compares its level with the interrupt mask in the processor status. When a request passes, the unit raises an acknowledge toward the device, together with the level it is answering. It then captures the vector number the device returns on the data bus. If the device never answers, the unit substitutes an automatic vector.

After the vector is known, the unit presents the handler table address, which is four times the vector number. In the same cycle it issues a one-cycle request to load new status bits into the core: supervisor set, trace cleared, and mask raised to the accepted level. The status that was in force before entry is kept in a small last-in first-out store. A return-from-exception strobe restores it, so nested handlers unwind in order.

Top module: `irq_accept_unit`

## Requirements
- R1: Request line bit k stands for level k+1. When several lines are high at a boundary, the highest level is the one acknowledged.
- R2: A level from 1 to 6 is accepted only when it is strictly greater than the 3-bit mask input. Otherwise no acknowledge is raised.
- R3: Level 7 is accepted whatever the mask value, including a mask of 7.
- R4: A request is accepted only on a cycle in which the instruction-boundary strobe is high. A request that is held without a strobe raises no acknowledge.
- R5: The acknowledge rises in the cycle after acceptance, with the accepted level on the level output (0 when idle). It stays high until a data-valid cycle, and the data bus is captured as the vector number on that edge.
- R6: In the cycle after the vector is captured, vector-valid is high for exactly one cycle, and the address output equals 4 times the vector number (10 bits).
- R7: In that same cycle, the status-load pulse is high with supervisor 1, trace 0 and mask equal to the accepted level.
- R8: If data-valid does not arrive, the acknowledge drops after exactly 16 cycles, and the vector becomes 24 plus the accepted level.
- R9: While a handler runs with the mask at its level, a higher level is still accepted and nests on top of it.
- R10: A return strobe while idle pops the most recently saved status (supervisor, trace, mask as they were at acceptance) and presents it with a status-load pulse in the next cycle. A return strobe with nothing saved produces no pulse. A return strobe takes precedence over a boundary strobe in the same cycle.
- R11: After reset, acknowledge, vector-valid and status-load are low and the level output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 7 | Request lines, bit k is level k+1 |
| insn_done_i | input | 1 | One-cycle strobe at an instruction boundary |
| rte_i | input | 1 | Return-from-exception strobe |
| sr_super_i | input | 1 | Current supervisor bit |
| sr_trace_i | input | 1 | Current trace bit |
| sr_mask_i | input | 3 | Current interrupt mask |
| data_bus_i | input | 8 | Vector number driven by the device |
| data_valid_i | input | 1 | Device has placed its vector on the bus |
| ack_o | output | 1 | Acknowledge to the device |
| ack_level_o | output | 3 | Level being acknowledged, 0 when idle |
| vec_valid_o | output | 1 | Vector address valid, one cycle |
| vec_addr_o | output | 10 | Handler table address, vector times 4 |
| sr_load_o | output | 1 | Load the new status bits into the core |
| new_super_o | output | 1 | New supervisor bit |
| new_trace_o | output | 1 | New trace bit |
| new_mask_o | output | 3 | New interrupt mask |

## Verification
The bench raises a request whose level equals the mask. A unit that compared with greater-or-equal would acknowledge it. The bench also raises level 7 with a mask of 7, which a unit that masked the top level would ignore. A silent device checks that the acknowledge lasts exactly sixteen cycles and yields vector 24 plus the level. An off-by-one counter or a wrong base shows up as a wrong duration or a wrong address. A two-deep nesting followed by two returns and a third, spare return exposes several faults: a store that loses order would restore the wrong mask, one that forgets the pre-handler trace bit would restore the wrong trace, and one that answers an empty pop would give a spurious load pulse.

// File: rtl/irq_accept_pkg.sv
`timescale 1ns/1ps
package irq_accept_pkg;
   typedef enum logic [1:0] {
      ACK_IDLE = 2'd0,
      ACK_WAIT = 2'd1,
      ACK_DONE = 2'd2
   } ack_state_e;

   localparam int IRQ_LEVELS_DEF  = 7;
   localparam int IRQ_VEC_W_DEF   = 8;
   localparam int IRQ_TIMEOUT_DEF = 16;
   localparam int IRQ_AUTO_DEF    = 24;
   localparam int IRQ_NEST_DEF    = 8;
endpackage

// File: rtl/irq_level_pick.sv
`timescale 1ns/1ps
module irq_level_pick #(
   parameter int LEVELS         = 7,
   parameter int LVL_W          = 3,
   parameter bit TOP_UNMASKABLE = 1'b1
) (
   input  logic [LEVELS-1:0] req_i,
   input  logic [LVL_W-1:0]  mask_i,
   output logic [LVL_W-1:0]  lvl_o,
   output logic              take_o
);
   logic above;

   always_comb begin
      lvl_o = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (req_i[i]) lvl_o = LVL_W'(i + 1);
      end
   end

   assign above = (lvl_o > mask_i);

   generate
      if (TOP_UNMASKABLE) begin : g_nmi
         assign take_o = above || (lvl_o == LVL_W'(LEVELS));
      end else begin : g_plain
         assign take_o = above;
      end
   endgenerate
endmodule

// File: rtl/irq_ack_seq.sv
`timescale 1ns/1ps
module irq_ack_seq
   import irq_accept_pkg::*;
#(
   parameter int LVL_W     = 3,
   parameter int VEC_W     = 8,
   parameter int TIMEOUT   = 16,
   parameter int AUTO_BASE = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LVL_W-1:0] start_lvl_i,
   input  logic [VEC_W-1:0] data_bus_i,
   input  logic             data_valid_i,
   output logic             busy_o,
   output logic             ack_o,
   output logic [LVL_W-1:0] ack_lvl_o,
   output logic             finish_o,
   output logic [LVL_W-1:0] cur_lvl_o,
   output logic             done_o,
   output logic [VEC_W-1:0] vec_o
);
   localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

   ack_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [LVL_W-1:0] lvl;
   logic [VEC_W-1:0] vec;
   logic             expired;
   logic [VEC_W-1:0] auto_vec;

   assign expired  = (cnt == CNT_W'(TIMEOUT - 1));
   assign finish_o = (st == ACK_WAIT) && (data_valid_i || expired);
   assign auto_vec = VEC_W'(AUTO_BASE) + VEC_W'(lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ACK_IDLE;
         cnt <= '0;
         lvl <= '0;
         vec <= '0;
      end else begin
         case (st)
            ACK_IDLE: begin
               if (start_i) begin
                  st  <= ACK_WAIT;
                  lvl <= start_lvl_i;
                  cnt <= '0;
               end
            end
            ACK_WAIT: begin
               if (finish_o) begin
                  st  <= ACK_DONE;
                  vec <= data_valid_i ? data_bus_i : auto_vec;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ACK_IDLE;
         endcase
      end
   end

   assign busy_o    = (st != ACK_IDLE);
   assign ack_o     = (st == ACK_WAIT);
   assign ack_lvl_o = ack_o ? lvl : '0;
   assign cur_lvl_o = lvl;
   assign done_o    = (st == ACK_DONE);
   assign vec_o     = vec;
endmodule

// File: rtl/irq_sr_keep.sv
`timescale 1ns/1ps
module irq_sr_keep #(
   parameter int DEPTH = 8,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [LVL_W+1:0] push_sr_i,
   input  logic             pop_i,
   input  logic             enter_i,
   input  logic [LVL_W-1:0] enter_lvl_i,
   output logic             empty_o,
   output logic             load_o,
   output logic [LVL_W+1:0] new_sr_o
);
   localparam int SR_W  = LVL_W + 2;
   localparam int OCC_W = $clog2(DEPTH + 1);

   logic [SR_W-1:0]  stk [DEPTH];
   logic [OCC_W-1:0] occ;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [SR_W-1:0] from_up;
         logic [SR_W-1:0] from_down;
         if (g == 0) begin : g_first
            assign from_up = push_sr_i;
         end else begin : g_rest
            assign from_up = stk[g-1];
         end
         if (g == DEPTH - 1) begin : g_last
            assign from_down = '0;
         end else begin : g_inner
            assign from_down = stk[g+1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stk[g] <= '0;
            else if (push_i) stk[g] <= from_up;
            else if (pop_i)  stk[g] <= from_down;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= '0;
      end else if (push_i) begin
         if (occ != OCC_W'(DEPTH)) occ <= occ + 1'b1;
      end else if (pop_i) begin
         occ <= occ - 1'b1;
      end
   end

   assign empty_o = (occ == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_o   <= 1'b0;
         new_sr_o <= '0;
      end else begin
         load_o <= 1'b0;
         if (enter_i) begin
            load_o   <= 1'b1;
            new_sr_o <= {1'b1, 1'b0, enter_lvl_i};
         end else if (pop_i) begin
            load_o   <= 1'b1;
            new_sr_o <= stk[0];
         end
      end
   end
endmodule

// File: rtl/irq_accept_unit.sv
`timescale 1ns/1ps
module irq_accept_unit
   import irq_accept_pkg::*;
#(
   parameter int LEVELS    = IRQ_LEVELS_DEF,
   parameter int VEC_W     = IRQ_VEC_W_DEF,
   parameter int TIMEOUT   = IRQ_TIMEOUT_DEF,
   parameter int AUTO_BASE = IRQ_AUTO_DEF,
   parameter int NEST      = IRQ_NEST_DEF,
   parameter int LVL_W     = $clog2(LEVELS + 1),
   parameter int ADDR_W    = VEC_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] irq_i,
   input  logic              insn_done_i,
   input  logic              rte_i,
   input  logic              sr_super_i,
   input  logic              sr_trace_i,
   input  logic [LVL_W-1:0]  sr_mask_i,
   input  logic [VEC_W-1:0]  data_bus_i,
   input  logic              data_valid_i,
   output logic              ack_o,
   output logic [LVL_W-1:0]  ack_level_o,
   output logic              vec_valid_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic              sr_load_o,
   output logic              new_super_o,
   output logic              new_trace_o,
   output logic [LVL_W-1:0]  new_mask_o
);
   generate
      if (LEVELS < 1 || LEVELS != (1 << LVL_W) - 1) begin : g_bad_levels
         $error("LEVELS must fill the mask field exactly");
      end
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("TIMEOUT must be at least 2");
      end
      if (AUTO_BASE + LEVELS >= (1 << VEC_W)) begin : g_bad_auto
         $error("autovector range exceeds vector width");
      end
      if (NEST < 1) begin : g_bad_nest
         $error("NEST must be at least 1");
      end
   endgenerate

   logic [LVL_W-1:0] pick_lvl;
   logic             pick_take;
   logic             busy;
   logic             finish;
   logic [LVL_W-1:0] cur_lvl;
   logic [VEC_W-1:0] vec;
   logic             empty;
   logic             start;
   logic             pop;
   logic [LVL_W+1:0] new_sr;

   irq_level_pick #(
      .LEVELS         (LEVELS),
      .LVL_W          (LVL_W),
      .TOP_UNMASKABLE (1'b1)
   ) u_pick (
      .req_i  (irq_i),
      .mask_i (sr_mask_i),
      .lvl_o  (pick_lvl),
      .take_o (pick_take)
   );

   assign pop   = rte_i && !busy && !empty;
   assign start = insn_done_i && pick_take && !busy && !rte_i;

   irq_ack_seq #(
      .LVL_W     (LVL_W),
      .VEC_W     (VEC_W),
      .TIMEOUT   (TIMEOUT),
      .AUTO_BASE (AUTO_BASE)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .start_lvl_i  (pick_lvl),
      .data_bus_i   (data_bus_i),
      .data_valid_i (data_valid_i),
      .busy_o       (busy),
      .ack_o        (ack_o),
      .ack_lvl_o    (ack_level_o),
      .finish_o     (finish),
      .cur_lvl_o    (cur_lvl),
      .done_o       (vec_valid_o),
      .vec_o        (vec)
   );

   irq_sr_keep #(
      .DEPTH (NEST),
      .LVL_W (LVL_W)
   ) u_keep (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (start),
      .push_sr_i   ({sr_super_i, sr_trace_i, sr_mask_i}),
      .pop_i       (pop),
      .enter_i     (finish),
      .enter_lvl_i (cur_lvl),
      .empty_o     (empty),
      .load_o      (sr_load_o),
      .new_sr_o    (new_sr)
   );

   assign vec_addr_o  = {vec, 2'b00};
   assign new_super_o = new_sr[LVL_W+1];
   assign new_trace_o = new_sr[LVL_W];
   assign new_mask_o  = new_sr[LVL_W-1:0];
endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk #(
   parameter int LEVELS  = 7,
   parameter int VEC_W   = 8,
   parameter int TIMEOUT = 16,
   parameter int LVL_W   = 3,
   parameter int ADDR_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LEVELS-1:0] irq_i,
   input logic              insn_done_i,
   input logic              rte_i,
   input logic [LVL_W-1:0]  sr_mask_i,
   input logic [VEC_W-1:0]  data_bus_i,
   input logic              data_valid_i,
   input logic              ack_o,
   input logic [LVL_W-1:0]  ack_level_o,
   input logic              vec_valid_o,
   input logic [ADDR_W-1:0] vec_addr_o,
   input logic              sr_load_o,
   input logic              new_super_o,
   input logic              new_trace_o,
   input logic [LVL_W-1:0]  new_mask_o
);
   localparam int HC_W = $clog2(TIMEOUT + 2);
   logic [HC_W-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_cnt <= '0;
      else if (ack_o) hold_cnt <= hold_cnt + 1'b1;
      else            hold_cnt <= '0;
   end

   assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> (ack_level_o > $past(sr_mask_i) || ack_level_o == LVL_W'(LEVELS)));

   assert_top_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_o && !vec_valid_o && insn_done_i && !rte_i && irq_i[LEVELS-1])
      |=> (ack_o && ack_level_o == LVL_W'(LEVELS)));

   assert_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(insn_done_i));

   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && data_valid_i)
      |=> (!ack_o && vec_valid_o && vec_addr_o == {$past(data_bus_i), 2'b00}));

   assert_addr_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |=> !vec_valid_o);

   assert_entry_sr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> (sr_load_o && new_super_o && !new_trace_o
                       && new_mask_o == $past(ack_level_o)));

   assert_ack_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_cnt <= HC_W'(TIMEOUT));
endmodule

bind irq_accept_unit irq_accept_chk #(
   .LEVELS  (LEVELS),
   .VEC_W   (VEC_W),
   .TIMEOUT (TIMEOUT),
   .LVL_W   (LVL_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_i        (irq_i),
   .insn_done_i  (insn_done_i),
   .rte_i        (rte_i),
   .sr_mask_i    (sr_mask_i),
   .data_bus_i   (data_bus_i),
   .data_valid_i (data_valid_i),
   .ack_o        (ack_o),
   .ack_level_o  (ack_level_o),
   .vec_valid_o  (vec_valid_o),
   .vec_addr_o   (vec_addr_o),
   .sr_load_o    (sr_load_o),
   .new_super_o  (new_super_o),
   .new_trace_o  (new_trace_o),
   .new_mask_o   (new_mask_o)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] irq = '0;
   logic       insn_done = 1'b0;
   logic       rte = 1'b0;
   logic       sr_super = 1'b0;
   logic       sr_trace = 1'b0;
   logic [2:0] sr_mask = '0;
   logic [7:0] data_bus = '0;
   logic       data_valid = 1'b0;
   logic       ack;
   logic [2:0] ack_level;
   logic       vec_valid;
   logic [9:0] vec_addr;
   logic       sr_load;
   logic       new_super;
   logic       new_trace;
   logic [2:0] new_mask;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_accept_unit u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_i        (irq),
      .insn_done_i  (insn_done),
      .rte_i        (rte),
      .sr_super_i   (sr_super),
      .sr_trace_i   (sr_trace),
      .sr_mask_i    (sr_mask),
      .data_bus_i   (data_bus),
      .data_valid_i (data_valid),
      .ack_o        (ack),
      .ack_level_o  (ack_level),
      .vec_valid_o  (vec_valid),
      .vec_addr_o   (vec_addr),
      .sr_load_o    (sr_load),
      .new_super_o  (new_super),
      .new_trace_o  (new_trace),
      .new_mask_o   (new_mask)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      irq = '0; insn_done = 1'b0; rte = 1'b0; data_valid = 1'b0;
      sr_super = 1'b0; sr_trace = 1'b0; sr_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Boundary pulse, then acknowledge, vector capture (or timeout) and entry status.
   task automatic accept(input string tag, input int lvl, input int dev_vec, input bit respond);
      int held;
      int exp_vec;
      @(negedge clk) insn_done = 1'b1;
      @(negedge clk) insn_done = 1'b0;
      check({tag, " R5 ack raised"}, ack, 1);
      check({tag, " R1 ack level"}, ack_level, lvl);
      if (respond) begin
         data_bus = 8'(dev_vec); data_valid = 1'b1;
         @(negedge clk) data_valid = 1'b0;
         exp_vec = dev_vec;
      end else begin
         held = 1;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!ack) break;
            held++;
         end
         check({tag, " R8 ack duration"}, held, 16);
         exp_vec = 24 + lvl;
      end
      check({tag, " R5 ack dropped"}, ack, 0);
      check({tag, " R6 vec valid"}, vec_valid, 1);
      check({tag, " R6 vec addr"}, vec_addr, exp_vec * 4);
      check({tag, " R7 sr load"}, sr_load, 1);
      check({tag, " R7 super"}, new_super, 1);
      check({tag, " R7 trace"}, new_trace, 0);
      check({tag, " R7 mask"}, new_mask, lvl);
      sr_super = new_super; sr_trace = new_trace; sr_mask = new_mask;
      irq = '0;
      @(negedge clk);
      check({tag, " R6 single cycle"}, vec_valid, 0);
   endtask

   task automatic expect_no_ack(input string tag);
      @(negedge clk) insn_done = 1'b1;
      @(negedge clk) insn_done = 1'b0;
      check(tag, ack, 0);
      repeat (2) @(negedge clk);
      check(tag, ack, 0);
   endtask

   task automatic do_return(input string tag, input bit exp_load, input int s, input int t, input int m);
      @(negedge clk) rte = 1'b1;
      @(negedge clk) rte = 1'b0;
      check({tag, " R10 load"}, sr_load, exp_load);
      if (exp_load) begin
         check({tag, " R10 super"}, new_super, s);
         check({tag, " R10 trace"}, new_trace, t);
         check({tag, " R10 mask"}, new_mask, m);
         sr_super = new_super; sr_trace = new_trace; sr_mask = new_mask;
      end
   endtask

   task automatic t_reset_state();
      check("R11 ack after reset", ack, 0);
      check("R11 level after reset", ack_level, 0);
      check("R11 vec valid after reset", vec_valid, 0);
      check("R11 load after reset", sr_load, 0);
   endtask

   task automatic t_nesting();
      do_reset();
      sr_super = 1'b0; sr_trace = 1'b1; sr_mask = 3'd0;
      irq = 7'b0000010;
      accept("R9 outer level 2", 2, 8'h40, 1'b1);
      irq = 7'b0000001;
      expect_no_ack("R2 level 1 under mask 2");
      irq = 7'b0100000;
      accept("R9 nested level 6", 6, 8'h50, 1'b1);
      do_return("R10 first pop", 1'b1, 1, 0, 2);
      do_return("R10 second pop", 1'b1, 0, 1, 0);
      do_return("R10 empty pop", 1'b0, 0, 0, 0);
   endtask

   task automatic t_single();
      sr_mask = 3'd0;
      irq = 7'b0000100;
      accept("R5 single level 3", 3, 64, 1'b1);
   endtask

   task automatic t_priority();
      sr_mask = 3'd0;
      irq = 7'b0011010;
      accept("R1 levels 2 4 5", 5, 8'hC3, 1'b1);
   endtask

   task automatic t_mask();
      sr_mask = 3'd4;
      irq = 7'b0001000;
      expect_no_ack("R2 level equal to mask");
      irq = 7'b0011000;
      sr_mask = 3'd4;
      accept("R2 level 5 over mask 4", 5, 8'h81, 1'b1);
   endtask

   task automatic t_top_level();
      sr_mask = 3'd7;
      irq = 7'b1000000;
      accept("R3 level 7 mask 7", 7, 8'hFF, 1'b1);
   endtask

   task automatic t_boundary();
      sr_mask = 3'd0;
      irq = 7'b0000100;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R4 no strobe no ack", ack, 0);
      end
      accept("R4 after strobe", 3, 8'h44, 1'b1);
   endtask

   task automatic t_timeout();
      sr_mask = 3'd1;
      irq = 7'b0000010;
      accept("R8 silent device level 2", 2, 0, 1'b0);
      sr_mask = 3'd0;
      irq = 7'b0100000;
      accept("R8 silent device level 6", 6, 0, 1'b0);
   endtask

   task automatic t_rte_precedence();
      do_reset();
      sr_super = 1'b0; sr_trace = 1'b0; sr_mask = 3'd0;
      irq = 7'b0000001;
      accept("R10 setup level 1", 1, 8'h42, 1'b1);
      irq = 7'b0010000;
      @(negedge clk) begin insn_done = 1'b1; rte = 1'b1; end
      @(negedge clk) begin insn_done = 1'b0; rte = 1'b0; end
      check("R10 rte wins over boundary ack", ack, 0);
      check("R10 rte wins load", sr_load, 1);
      check("R10 rte wins mask", new_mask, 0);
      irq = '0;
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_single();
      t_priority();
      t_mask();
      t_top_level();
      t_boundary();
      t_timeout();
      t_nesting();
      t_rte_precedence();
      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule